// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block moves a receive DMA engine from one in-memory descriptor to the next. For each descriptor it reads four 32-bit words in order: status, control, first address and second address. It checks that the descriptor is owned by the hardware. It then offers the frame engine up to two legal buffers, one at a time. When the engine reports that a buffer is full or that the frame has ended, the walker writes the status word back. That word holds the first and last flags, the frame length and the error bits. The walker then computes where the next descriptor lives.

Three layouts for the next descriptor are supported. Sequential lists step forward by a fixed descriptor size. Chained lists reuse the second address word as a pointer. Any descriptor can be marked as the end of the ring, which sends the walk back to the list base. A frame larger than one descriptor continues across several. A per-descriptor flag can stop a completed frame from raising the receive interrupt. The walk halts at the first descriptor that software still owns, and it restarts on a new start pulse.

Top module: `rx_desc_walker`

## Requirements
- R1: After start, the descriptor at the current address is read at byte offsets 0, 4, 8 and 12, in that order. Each request holds its address until acknowledged. A used descriptor gets exactly one write, at offset 0.
- R2: If bit 31 (ownership) of the status word reads 0, the walker stops issuing requests and presents no buffer. It sets buf_unavail, which stays set until the next start; start is accepted while stopped.
- R3: The next descriptor address is the list base when control bit 15 is set. Otherwise it is the second address word when control bit 14 is set. Otherwise it is the current address plus 32. Bit 15 wins over bit 14.
- R4: Buffer 1 (address word 2, size in control bits 12:0) is offered first. Buffer 2 (address word 3, size in control bits 28:16) is offered only if the frame did not end in buffer 1. When control bit 14 is set, the buffer 2 size counts as zero.
- R5: A buffer whose size is zero, or not a multiple of 4, is never offered. A nonzero size with either of its two low bits set raises cfg_err, which stays set until the next start.
- R6: A frame that does not fit in a descriptor closes that descriptor with the last flag clear and continues in the next one. Status bit 9 (first) is set only in the descriptor where the frame starts.
- R7: In the written-back word, bit 31 is 0 and bit 8 marks the last descriptor of a frame. When bit 8 is set, bits 29:16 hold the total frame length and bits 3, 2, 1 and 0 carry the receive-error, dribble, CRC and extended-status reports given with end of frame. When bit 8 is clear, all of these fields are 0.
- R8: Writing back a last descriptor whose control bit 31 is clear sets rx_irq. A descriptor with control bit 31 set never sets it. int_ack clears it, and a set in the same cycle wins.
- R9: A descriptor with no usable buffer is written back as all zeros, and the walk continues at its next address.
- R10: During and after reset, no request or buffer is offered, and rx_irq, buf_unavail and cfg_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin walking at list_base (accepted when idle or stopped) |
| list_base | input | AW | Address of the first descriptor and ring return point |
| mem_req | output | 1 | Descriptor word access request |
| mem_we | output | 1 | Access is a write (status write-back) |
| mem_addr | output | AW | Byte address of the descriptor word |
| mem_wdata | output | 32 | Status word to write |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| buf_valid | output | 1 | A buffer is offered to the frame engine |
| buf_addr | output | AW | Address of the offered buffer |
| buf_size | output | 13 | Size in bytes of the offered buffer |
| fe_done | input | 1 | Engine finished with the offered buffer |
| fe_bytes | input | 13 | Bytes written into the buffer |
| fe_eof | input | 1 | Frame ended in this buffer |
| fe_rx_err | input | 1 | Receive error report |
| fe_dribble | input | 1 | Odd-nibble report |
| fe_crc_err | input | 1 | CRC error report |
| fe_ext_sts | input | 1 | Extended status available report |
| int_ack | input | 1 | Clears rx_irq |
| rx_irq | output | 1 | Receive interrupt status |
| buf_unavail | output | 1 | Walk stopped on a descriptor not owned by hardware |
| cfg_err | output | 1 | A misaligned buffer size was seen |

## Verification
The assertions assume that the memory side holds its acknowledge for single cycles and answers only a pending request. They also assume that fe_done comes only while a buffer is offered, and that fe_bytes never exceeds the offered size. The bench models memory with a registered one-cycle acknowledge, and its frame engine answers only an offered buffer, with the smaller of the remaining frame bytes and the buffer size. A sweep covers every combination of the two link flags, both buffer sizes (zero, misaligned and legal) and two frame lengths, so each offer, write-back and next address is predicted from the requirements alone.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_PLAN, S_BUF1, S_BUF2, S_WB, S_STOP
  } walk_state_t;

  localparam int OWN_POS   = 31;
  localparam int NOINT_POS = 31;
  localparam int EOR_POS   = 15;
  localparam int CHN_POS   = 14;
  localparam int FIRST_POS = 9;
  localparam int LAST_POS  = 8;
  localparam int SZ_W      = 13;
  localparam int B1_LO     = 0;
  localparam int B2_LO     = 16;
  localparam int LEN_LO    = 16;
  localparam int LEN_W     = 14;

  typedef struct packed {
    logic rx_err;
    logic dribble;
    logic crc;
    logic ext;
  } rx_flags_t;

  function automatic logic size_usable(input logic [SZ_W-1:0] s);
    return (s != '0) && (s[1:0] == 2'b00);
  endfunction

  function automatic logic size_misaligned(input logic [SZ_W-1:0] s);
    return s[1:0] != 2'b00;
  endfunction

  function automatic logic [31:0] pack_status(input logic first, input logic last,
                                              input logic [LEN_W-1:0] len,
                                              input rx_flags_t f);
    logic [31:0] w;
    w = '0;
    w[FIRST_POS] = first;
    w[LAST_POS]  = last;
    if (last) begin
      w[LEN_LO +: LEN_W] = len;
      w[3] = f.rx_err;
      w[2] = f.dribble;
      w[1] = f.crc;
      w[0] = f.ext;
    end
    return w;
  endfunction

endpackage

// File: rtl/rxw_ctl_decode.sv
module rxw_ctl_decode
  import rxw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic [31:0]     ctl,
  input  logic [AW-1:0]   ptr2,
  input  logic [AW-1:0]   cur,
  input  logic [AW-1:0]   base,
  output logic [AW-1:0]   nxt,
  output logic [SZ_W-1:0] b1_sz,
  output logic [SZ_W-1:0] b2_sz,
  output logic            b1_use,
  output logic            b2_use,
  output logic            cfg_bad,
  output logic            no_int
);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

  logic chained, ring_end;

  always_comb begin
    ring_end = ctl[EOR_POS];
    chained  = ctl[CHN_POS];
    no_int   = ctl[NOINT_POS];
    b1_sz    = ctl[B1_LO +: SZ_W];
    b2_sz    = chained ? '0 : ctl[B2_LO +: SZ_W];
    b1_use   = size_usable(b1_sz);
    b2_use   = size_usable(b2_sz);
    cfg_bad  = ((b1_sz != '0) && size_misaligned(b1_sz)) ||
               ((b2_sz != '0) && size_misaligned(b2_sz));
    if (ring_end)     nxt = base;
    else if (chained) nxt = ptr2;
    else              nxt = cur + STRIDE;
  end

endmodule

// File: rtl/rxw_status_pack.sv
module rxw_status_pack
  import rxw_pkg::*;
(
  input  logic             first,
  input  logic             last,
  input  logic [LEN_W-1:0] len,
  input  rx_flags_t        flags,
  output logic [31:0]      word
);
  always_comb word = pack_status(first, last, len, flags);
endmodule

// File: rtl/rxw_irq_unit.sv
module rxw_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic sts
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sts <= 1'b0;
    else if (set_evt) sts <= 1'b1;
    else if (clr)     sts <= 1'b0;
  end
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
  import rxw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   list_base,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ack,
  output logic            buf_valid,
  output logic [AW-1:0]   buf_addr,
  output logic [SZ_W-1:0] buf_size,
  input  logic            fe_done,
  input  logic [SZ_W-1:0] fe_bytes,
  input  logic            fe_eof,
  input  logic            fe_rx_err,
  input  logic            fe_dribble,
  input  logic            fe_crc_err,
  input  logic            fe_ext_sts,
  input  logic            int_ack,
  output logic            rx_irq,
  output logic            buf_unavail,
  output logic            cfg_err
);
  localparam int WORD_B = 4;

  walk_state_t      state_q;
  logic [AW-1:0]    cur_q, base_q, bp1_q, bp2_q;
  logic [31:0]      ctl_q;
  logic             in_frame_q, first_q, last_q, unavail_q, cfg_q;
  logic [LEN_W-1:0] len_acc_q, wb_len_q;
  rx_flags_t        flags_q;

  logic [AW-1:0]    nxt_addr;
  logic [SZ_W-1:0]  b1_sz, b2_sz;
  logic             b1_use, b2_use, cfg_bad, no_int;
  logic [31:0]      wb_word;
  rx_flags_t        fe_flags;
  logic [LEN_W-1:0] len_sum;
  logic [AW-1:0]    word_off;

  // named events for the checker
  logic             evt_adv, evt_irq_set, evt_take;

  rxw_ctl_decode #(.AW(AW), .DESC_BYTES(DESC_BYTES)) dec_i (
    .ctl(ctl_q), .ptr2(bp2_q), .cur(cur_q), .base(base_q), .nxt(nxt_addr),
    .b1_sz(b1_sz), .b2_sz(b2_sz), .b1_use(b1_use), .b2_use(b2_use),
    .cfg_bad(cfg_bad), .no_int(no_int)
  );

  rxw_status_pack pack_i (
    .first(first_q), .last(last_q), .len(wb_len_q), .flags(flags_q), .word(wb_word)
  );

  always_comb begin
    fe_flags    = '{rx_err: fe_rx_err, dribble: fe_dribble, crc: fe_crc_err, ext: fe_ext_sts};
    len_sum     = len_acc_q + LEN_W'(fe_bytes);
    evt_adv     = (state_q == S_WB) && mem_ack;
    evt_irq_set = evt_adv && last_q && !no_int;
    evt_take    = buf_valid && fe_done;
  end

  rxw_irq_unit irq_i (
    .clk(clk), .rst_n(rst_n), .set_evt(evt_irq_set), .clr(int_ack), .sts(rx_irq)
  );

  always_comb begin
    case (state_q)
      S_RD1:   word_off = AW'(1 * WORD_B);
      S_RD2:   word_off = AW'(2 * WORD_B);
      S_RD3:   word_off = AW'(3 * WORD_B);
      default: word_off = '0;
    endcase
    mem_req   = (state_q == S_RD0) || (state_q == S_RD1) || (state_q == S_RD2) ||
                (state_q == S_RD3) || (state_q == S_WB);
    mem_we    = (state_q == S_WB);
    mem_addr  = cur_q + word_off;
    mem_wdata = wb_word;
    buf_valid = (state_q == S_BUF1) || (state_q == S_BUF2);
    buf_addr  = (state_q == S_BUF2) ? bp2_q : bp1_q;
    buf_size  = (state_q == S_BUF2) ? b2_sz : b1_sz;
    buf_unavail = unavail_q;
    cfg_err     = cfg_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cur_q      <= '0;
      base_q     <= '0;
      ctl_q      <= '0;
      bp1_q      <= '0;
      bp2_q      <= '0;
      in_frame_q <= 1'b0;
      len_acc_q  <= '0;
      wb_len_q   <= '0;
      first_q    <= 1'b0;
      last_q     <= 1'b0;
      flags_q    <= '0;
      unavail_q  <= 1'b0;
      cfg_q      <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE, S_STOP: begin
          if (start) begin
            cur_q      <= list_base;
            base_q     <= list_base;
            unavail_q  <= 1'b0;
            cfg_q      <= 1'b0;
            in_frame_q <= 1'b0;
            len_acc_q  <= '0;
            state_q    <= S_RD0;
          end
        end
        S_RD0: begin
          if (mem_ack) begin
            if (mem_rdata[OWN_POS]) begin
              state_q <= S_RD1;
            end else begin
              unavail_q <= 1'b1;
              state_q   <= S_STOP;
            end
          end
        end
        S_RD1: begin
          if (mem_ack) begin
            ctl_q   <= mem_rdata;
            state_q <= S_RD2;
          end
        end
        S_RD2: begin
          if (mem_ack) begin
            bp1_q   <= mem_rdata[AW-1:0];
            state_q <= S_RD3;
          end
        end
        S_RD3: begin
          if (mem_ack) begin
            bp2_q   <= mem_rdata[AW-1:0];
            state_q <= S_PLAN;
          end
        end
        S_PLAN: begin
          if (cfg_bad) cfg_q <= 1'b1;
          first_q  <= !in_frame_q && (b1_use || b2_use);
          last_q   <= 1'b0;
          flags_q  <= '0;
          wb_len_q <= '0;
          if (b1_use)      state_q <= S_BUF1;
          else if (b2_use) state_q <= S_BUF2;
          else             state_q <= S_WB;
        end
        S_BUF1, S_BUF2: begin
          if (fe_done) begin
            if (fe_eof) begin
              last_q     <= 1'b1;
              flags_q    <= fe_flags;
              wb_len_q   <= len_sum;
              len_acc_q  <= '0;
              in_frame_q <= 1'b0;
              state_q    <= S_WB;
            end else begin
              len_acc_q  <= len_sum;
              in_frame_q <= 1'b1;
              state_q    <= ((state_q == S_BUF1) && b2_use) ? S_BUF2 : S_WB;
            end
          end
        end
        S_WB: begin
          if (mem_ack) begin
            cur_q   <= nxt_addr;
            state_q <= S_RD0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxw_walker_chk.sv
module rxw_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          buf_valid,
  input logic [12:0]   buf_size,
  input logic          buf_unavail,
  input logic          rx_irq,
  input logic          evt_adv,
  input logic [31:0]   ctl_w,
  input logic [AW-1:0] base_w,
  input logic [AW-1:0] ptr2_w
);

  // R1: a pending request keeps its address and direction
  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2: stopped walker is silent
  assert_stop_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail |-> (!mem_req && !buf_valid));

  // R3: ring end returns to base, with priority over chaining
  assert_ring_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_adv && ctl_w[15]) |=> (mem_addr == $past(base_w)));

  assert_chain_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_adv && !ctl_w[15] && ctl_w[14]) |=> (mem_addr == $past(ptr2_w)));

  // R5: only legal sizes are offered
  assert_legal_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (buf_size != 13'd0 && buf_size[1:0] == 2'b00));

  // R7: written word releases ownership; non-last words carry no length or flags
  assert_wb_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  assert_wb_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_wdata[8]) |-> (mem_wdata[3:0] == 4'd0 && mem_wdata[29:16] == 14'd0));

  // R8: interrupt rises only after a last write-back that allows it
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(evt_adv && !ctl_w[31] && mem_wdata[8]));

  assert_irq_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_adv && ctl_w[31] && !rx_irq) |=> !rx_irq);

endmodule

bind rx_desc_walker rxw_walker_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .buf_valid(buf_valid), .buf_size(buf_size),
  .buf_unavail(buf_unavail), .rx_irq(rx_irq), .evt_adv(evt_adv), .ctl_w(ctl_q),
  .base_w(base_q), .ptr2_w(bp2_q)
);

// File: tb/rx_desc_walker_tb.sv
module rx_desc_walker_tb_top;
  localparam int CLK_NS = 10;
  localparam logic [31:0] BASE = 32'h80;
  localparam logic [31:0] BUF1A = 32'h100;
  localparam logic [31:0] PTR2 = 32'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] list_base = '0;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic buf_valid;
  logic [31:0] buf_addr;
  logic [12:0] buf_size;
  logic fe_done = 1'b0;
  logic [12:0] fe_bytes = '0;
  logic fe_eof = 1'b0, fe_rx_err = 1'b0, fe_dribble = 1'b0, fe_crc_err = 1'b0, fe_ext_sts = 1'b0;
  logic int_ack = 1'b0;
  logic rx_irq, buf_unavail, cfg_err;

  int n_tests = 0;
  int n_fail = 0;

  logic [31:0] mem [0:63];
  int fe_rem;
  logic [3:0] fe_flag_val;
  int n_pres;
  logic [31:0] pres_addr [0:7];
  logic [12:0] pres_size [0:7];
  int n_txn;
  logic [31:0] txn_addr [0:15];
  logic txn_we [0:15];
  logic [31:0] last_rd0;

  always #(CLK_NS/2) clk = ~clk;

  rx_desc_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .buf_valid(buf_valid), .buf_addr(buf_addr),
    .buf_size(buf_size), .fe_done(fe_done), .fe_bytes(fe_bytes), .fe_eof(fe_eof),
    .fe_rx_err(fe_rx_err), .fe_dribble(fe_dribble), .fe_crc_err(fe_crc_err),
    .fe_ext_sts(fe_ext_sts), .int_ack(int_ack), .rx_irq(rx_irq),
    .buf_unavail(buf_unavail), .cfg_err(cfg_err)
  );

  // memory model: one-cycle registered acknowledge
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      n_txn <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[7:2]];
      if (mem_req && mem_ack) begin
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (!mem_we && mem_addr[3:0] == 4'd0) last_rd0 <= mem_addr;
        if (n_txn < 16) begin
          txn_addr[n_txn] <= mem_addr;
          txn_we[n_txn] <= mem_we;
        end
        n_txn <= n_txn + 1;
      end
    end
  end

  // frame engine model
  initial begin
    forever begin
      @(negedge clk);
      fe_done = 1'b0;
      if (rst_n && buf_valid) begin
        if (n_pres < 8) begin
          pres_addr[n_pres] = buf_addr;
          pres_size[n_pres] = buf_size;
        end
        n_pres = n_pres + 1;
        fe_eof = (fe_rem <= int'(buf_size));
        fe_bytes = fe_eof ? 13'(fe_rem) : buf_size;
        fe_rem = fe_rem - int'(fe_bytes);
        {fe_rx_err, fe_dribble, fe_crc_err, fe_ext_sts} = fe_flag_val;
        fe_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[at[7:2]]     = 32'h8000_0000;
    mem[at[7:2] + 1] = w1;
    mem[at[7:2] + 2] = w2;
    mem[at[7:2] + 3] = w3;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    n_pres = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic kick(input logic [31:0] b);
    list_base = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_stop();
    int k;
    k = 0;
    while (!buf_unavail && k < 600) begin
      @(negedge clk);
      k++;
    end
    chk(buf_unavail, "R2 walker reached stop", 32'(buf_unavail), 32'd1);
  endtask

  task automatic run_case(input int mode, input int s1, input int s2, input int fb,
                          input logic [3:0] flg, input bit dic);
    logic [31:0] w1, exp_w, exp_next;
    bit u1, u2, last, first, cfg;
    int cap, np;
    logic [31:0] ea [0:1];
    int es [0:1];
    do_reset();
    clear_mem();
    w1 = {dic, 2'b00, 13'(s2), 1'(mode >> 1), 1'(mode), 1'b0, 13'(s1)};
    put_desc(BASE, w1, BUF1A, PTR2);
    fe_rem = fb;
    fe_flag_val = flg;
    kick(BASE);
    wait_stop();
    // expectations from the requirements
    u1 = (s1 != 0) && (s1 % 4 == 0);
    u2 = ((mode & 1) == 0) && (s2 != 0) && (s2 % 4 == 0);
    cap = (u1 ? s1 : 0) + (u2 ? s2 : 0);
    last = (cap > 0) && (fb <= cap);
    first = (cap > 0);
    cfg = ((s1 % 4) != 0) || (((mode & 1) == 0) && ((s2 % 4) != 0));
    exp_w = {2'b00, last ? 14'(fb) : 14'd0, 6'd0, first, last, 4'd0, last ? flg : 4'd0};
    if (mode >= 2) exp_next = BASE;
    else if (mode == 1) exp_next = PTR2;
    else exp_next = BASE + 32'd32;
    np = 0;
    if (u1) begin ea[np] = BUF1A; es[np] = s1; np++; end
    if (u2 && !(u1 && fb <= s1)) begin ea[np] = PTR2; es[np] = s2; np++; end
    // R1 access order
    chk(n_txn == 6, "R1 access count", 32'(n_txn), 32'd6);
    for (int i = 0; i < 4; i++)
      chk(txn_addr[i] == BASE + 32'(4 * i) && !txn_we[i], "R1 read order", txn_addr[i], BASE + 32'(4 * i));
    chk(txn_addr[4] == BASE && txn_we[4], "R1 single write-back", txn_addr[4], BASE);
    // R7 / R9 status word
    chk(mem[BASE[7:2]] == exp_w, (cap == 0) ? "R9 empty descriptor word" : "R7 status word",
        mem[BASE[7:2]], exp_w);
    // R3 next address
    chk(last_rd0 == exp_next, "R3 next descriptor", last_rd0, exp_next);
    // R8 interrupt
    chk(rx_irq == (last && !dic), "R8 interrupt", 32'(rx_irq), 32'(last && !dic));
    // R5 configuration error
    chk(cfg_err == cfg, "R5 misaligned size flag", 32'(cfg_err), 32'(cfg));
    // R4 buffer offers
    chk(n_pres == np, "R4 offer count", 32'(n_pres), 32'(np));
    for (int i = 0; i < np; i++) begin
      if (i < n_pres) begin
        chk(pres_addr[i] == ea[i], "R4 offer address", pres_addr[i], ea[i]);
        chk(int'(pres_size[i]) == es[i], "R4 offer size", 32'(pres_size[i]), 32'(es[i]));
      end
    end
  endtask

  initial begin
    fe_rem = 0;
    fe_flag_val = '0;
    n_pres = 0;
    last_rd0 = '0;
    rst_n = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!mem_req && !buf_valid, "R10 no activity in reset", {mem_req, buf_valid}, 32'd0);
    chk(!rx_irq && !buf_unavail && !cfg_err, "R10 flags clear in reset",
        {rx_irq, buf_unavail, cfg_err}, 32'd0);
    do_reset();
    chk(!mem_req && !buf_valid && !rx_irq, "R10 idle after reset", {mem_req, buf_valid, rx_irq}, 32'd0);

    // sweep of link modes, sizes and frame lengths
    begin
      int s1v [0:3] = '{0, 6, 8, 16};
      int s2v [0:3] = '{0, 4, 10, 12};
      int fbv [0:1] = '{5, 20};
      int idx;
      idx = 0;
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int f = 0; f < 2; f++) begin
              run_case(m, s1v[a], s2v[b], fbv[f], 4'(idx), idx[4]);
              idx++;
            end
    end

    // R6: frame spanning two descriptors
    do_reset();
    clear_mem();
    put_desc(BASE, {19'd0, 13'd8}, BUF1A, PTR2);
    put_desc(BASE + 32'd32, {16'h0000, 1'b1, 2'b00, 13'd16}, BUF1A, PTR2);
    fe_rem = 20;
    fe_flag_val = 4'hF;
    kick(BASE);
    wait_stop();
    chk(mem[BASE[7:2]] == 32'h0000_0200, "R6 first descriptor closed not last",
        mem[BASE[7:2]], 32'h0000_0200);
    chk(mem[BASE[7:2] + 8] == ((32'd20 << 16) | 32'h10F), "R6 continuation carries length",
        mem[BASE[7:2] + 8], (32'd20 << 16) | 32'h10F);
    chk(rx_irq, "R8 set after spanning frame", 32'(rx_irq), 32'd1);
    chk(last_rd0 == BASE, "R3 ring return", last_rd0, BASE);
    chk(n_txn == 11, "R1 two descriptors then stop", 32'(n_txn), 32'd11);

    // R8 acknowledge clears
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    chk(!rx_irq, "R8 cleared by ack", 32'(rx_irq), 32'd0);

    // R2 restart from stop clears the flag, then stops again on an unowned word
    kick(32'hC0);
    chk(!buf_unavail, "R2 start clears stop flag", 32'(buf_unavail), 32'd0);
    wait_stop();
    chk(last_rd0 == 32'hC0 && n_txn == 12, "R2 single read on unowned descriptor",
        last_rd0, 32'hC0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule